// File: doc/BRIEF.md
# Interrupt Aggregation and Halt Controller

This block gathers interrupt conditions from a DMA engine and from a bus-protocol engine into three sticky status banks. Each bank has its own enable register. The block sorts every pending condition into one of two classes. A fatal condition stops the instruction sequencer through a held halt request. A nonfatal condition only records its event. It drives an active-low interrupt pin, and a single control bit can hide that pin without discarding anything that is pending.

Software reaches the block through a small register port. Reading a status bank returns its contents and clears it. Writing an enable register arms that bank's conditions. Writing the control register sets or clears the pin mask. The same write can restart the sequencer and pulse the FIFO clear and flush strobes. A summary register at address 0 holds the DMA-pending bit, the protocol-pending bit, the halt state and the sampled FIFO-empty flag. Raising an interrupt never touches the FIFOs, so software reads the FIFO-empty flag after a DMA interrupt and decides whether to clear or flush.

Top module: `irq_halt_ctrl`

## Requirements
- R1: After reset, all status and enable registers read 0, the mask is clear, `halt_req_o` is 0, `irq_n_o` is 1 and all FIFO strobes are 0.
- R2: A high event input bit i sets bit i of its status register (address 1 for DMA, 2 for protocol bank A, 3 for protocol bank B) at the next edge. The bit stays set until a read of that address clears it at the edge that ends the read cycle. An event arriving in the same cycle as that read leaves its bit set.
- R3: The protocol bank A bit 1 event (selected) is dropped when `mode_target_i` is 0 (initiator). The bank A bit 2 event (reselected) is dropped when `mode_target_i` is 1 (target).
- R4: Every DMA status bit is fatal whatever its enable bit holds. While `seq_running_i` is high, a set fatal status bit raises `halt_req_o` at the edge after the status bit became visible.
- R5: Bank A bits 0 to 2 (complete, selected, reselected) and bank B bits 0 and 1 (general timer, handshake timer) are nonfatal while their enable bit is 0. They become fatal when it is 1. Every other protocol bit is always fatal. This rule is the same in both roles.
- R6: `irq_n_o` is 0 exactly when some status bit and its matching enable bit are both set and the mask (control bit 1) is 0. Setting the mask keeps status intact, and clearing the mask drives the pin low from the next cycle.
- R7: Once raised, `halt_req_o` stays high until a control write with bit 0 set. That write is ignored while any fatal status bit is set.
- R8: `dma_pend_o` is the OR of the DMA status bits and `proto_pend_o` is the OR of both protocol banks. Address 0 reads {4'b0, FIFO-empty, halt, protocol-pending, DMA-pending}, with bit 0 holding DMA-pending.
- R9: A control write with bit 2, 3 or 4 set pulses `clr_dma_fifo_o`, `clr_proto_fifo_o` or `flush_dma_fifo_o` respectively for exactly the one following cycle. No strobe appears without such a write. `dma_fifo_empty_i` is registered and shown on `fifo_empty_o`.
- R10: Enable registers at addresses 4, 5 and 6 read back what was written. Address 7 reads the mask in bit 1 and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_evt_i | input | 8 | One-cycle DMA condition strobes |
| proto_a_evt_i | input | 8 | One-cycle protocol bank A strobes |
| proto_b_evt_i | input | 8 | One-cycle protocol bank B strobes |
| mode_target_i | input | 1 | 0 initiator role, 1 target role |
| seq_running_i | input | 1 | Sequencer is executing |
| dma_fifo_empty_i | input | 1 | DMA FIFO empty flag |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, combinational on address |
| irq_n_o | output | 1 | Active-low interrupt pin |
| halt_req_o | output | 1 | Held sequencer halt request |
| dma_pend_o | output | 1 | Any DMA status bit set |
| proto_pend_o | output | 1 | Any protocol status bit set |
| fifo_empty_o | output | 1 | Registered FIFO-empty flag |
| clr_dma_fifo_o | output | 1 | DMA FIFO clear pulse |
| clr_proto_fifo_o | output | 1 | Protocol FIFO clear pulse |
| flush_dma_fifo_o | output | 1 | DMA FIFO flush pulse |

## Verification
Random sparse event strobes are mixed with random reads, writes, role changes and running-flag toggles. Each cycle's pin, halt and read data are compared with a bench model. This separates the always-fatal DMA bits from the enable-gated nonfatal protocol bits. Directed sequences cover the cases that random stimulus rarely reaches:
- a read that lands in the same cycle as a new event;
- role-dependent dropping of the selected and reselected strobes;
- a restart attempt while a fatal bit is still pending;
- clearing the mask while an interrupt waits.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int ST_W   = 8;
    localparam int ADDR_W = 3;
    localparam int NBANK  = 3;

    localparam logic [ADDR_W-1:0] A_TOP   = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT0 = 3'd1;
    localparam logic [ADDR_W-1:0] A_EN0   = 3'd4;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd7;

    localparam int C_START = 0;
    localparam int C_MASK  = 1;
    localparam int C_CLRD  = 2;
    localparam int C_CLRP  = 3;
    localparam int C_FLUSH = 4;

    localparam int B_SEL   = 1;
    localparam int B_RESEL = 2;

    localparam logic [ST_W-1:0] NF_DMA = 8'h00;
    localparam logic [ST_W-1:0] NF_PA  = 8'h07;
    localparam logic [ST_W-1:0] NF_PB  = 8'h03;

    function automatic logic [ST_W-1:0] nf_mask(input int idx);
        case (idx)
            1:       return NF_PA;
            2:       return NF_PB;
            default: return NF_DMA;
        endcase
    endfunction
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         rd_clr_i,
    input  logic         en_we_i,
    input  logic [W-1:0] en_wdata_i,
    output logic [W-1:0] st_o,
    output logic [W-1:0] en_o
);
    typedef struct packed {
        logic [W-1:0] st;
        logic [W-1:0] en;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d    = bank_q;
        bank_d.st = (rd_clr_i ? '0 : bank_q.st) | evt_i;
        if (en_we_i) bank_d.en = en_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign st_o = bank_q.st;
    assign en_o = bank_q.en;
endmodule

// File: rtl/irq_classify.sv
module irq_classify #(
    parameter int           W       = 8,
    parameter logic [W-1:0] NF_MASK = '0
) (
    input  logic [W-1:0] st_i,
    input  logic [W-1:0] en_i,
    output logic         fatal_o,
    output logic         irq_o
);
    logic [W-1:0] fatal_vec;
    always_comb begin
        fatal_vec = st_i & (~NF_MASK | en_i);
        fatal_o   = |fatal_vec;
        irq_o     = |(st_i & en_i);
    end
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we_i,
    input  logic start_i,
    input  logic mask_i,
    input  logic clr_dma_i,
    input  logic clr_proto_i,
    input  logic flush_i,
    input  logic fatal_any_i,
    input  logic irq_any_i,
    input  logic seq_running_i,
    input  logic fifo_empty_i,
    output logic irq_n_o,
    output logic halt_o,
    output logic mask_o,
    output logic clr_dma_o,
    output logic clr_proto_o,
    output logic flush_o,
    output logic fifo_empty_o
);
    typedef struct packed {
        logic mask;
        logic halt;
        logic clr_dma;
        logic clr_proto;
        logic flush;
        logic fempty;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  start_ok;

    always_comb begin
        ctrl_d           = ctrl_q;
        start_ok         = ctrl_we_i & start_i & ~fatal_any_i;
        ctrl_d.halt      = (ctrl_q.halt & ~start_ok) | (seq_running_i & fatal_any_i);
        if (ctrl_we_i) ctrl_d.mask = mask_i;
        ctrl_d.clr_dma   = ctrl_we_i & clr_dma_i;
        ctrl_d.clr_proto = ctrl_we_i & clr_proto_i;
        ctrl_d.flush     = ctrl_we_i & flush_i;
        ctrl_d.fempty    = fifo_empty_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign irq_n_o      = ~(irq_any_i & ~ctrl_q.mask);
    assign halt_o       = ctrl_q.halt;
    assign mask_o       = ctrl_q.mask;
    assign clr_dma_o    = ctrl_q.clr_dma;
    assign clr_proto_o  = ctrl_q.clr_proto;
    assign flush_o      = ctrl_q.flush;
    assign fifo_empty_o = ctrl_q.fempty;
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ST_W-1:0]   dma_evt_i,
    input  logic [ST_W-1:0]   proto_a_evt_i,
    input  logic [ST_W-1:0]   proto_b_evt_i,
    input  logic              mode_target_i,
    input  logic              seq_running_i,
    input  logic              dma_fifo_empty_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ST_W-1:0]   wdata_i,
    output logic [ST_W-1:0]   rd_data_o,
    output logic              irq_n_o,
    output logic              halt_req_o,
    output logic              dma_pend_o,
    output logic              proto_pend_o,
    output logic              fifo_empty_o,
    output logic              clr_dma_fifo_o,
    output logic              clr_proto_fifo_o,
    output logic              flush_dma_fifo_o
);
    logic [ST_W-1:0] evt   [NBANK];
    logic [ST_W-1:0] st    [NBANK];
    logic [ST_W-1:0] en    [NBANK];
    logic [NBANK-1:0] fatal_b, irq_b;
    logic            mask_q;
    logic            ctrl_we;
    logic [ST_W-1:0] role_keep;

    always_comb begin
        role_keep          = '1;
        role_keep[B_SEL]   = mode_target_i;
        role_keep[B_RESEL] = ~mode_target_i;
        evt[0] = dma_evt_i;
        evt[1] = proto_a_evt_i & role_keep;
        evt[2] = proto_b_evt_i;
    end

    for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
        localparam logic [ADDR_W-1:0] ST_ADDR = A_STAT0 + ADDR_W'(gi);
        localparam logic [ADDR_W-1:0] EN_ADDR = A_EN0 + ADDR_W'(gi);
        logic rd_clr, en_we;
        assign rd_clr = rd_en_i && (addr_i == ST_ADDR);
        assign en_we  = wr_en_i && (addr_i == EN_ADDR);

        irq_stat_bank #(.W(ST_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt[gi]),
            .rd_clr_i   (rd_clr),
            .en_we_i    (en_we),
            .en_wdata_i (wdata_i),
            .st_o       (st[gi]),
            .en_o       (en[gi])
        );

        irq_classify #(.W(ST_W), .NF_MASK(nf_mask(gi))) u_cls (
            .st_i    (st[gi]),
            .en_i    (en[gi]),
            .fatal_o (fatal_b[gi]),
            .irq_o   (irq_b[gi])
        );
    end

    assign ctrl_we = wr_en_i && (addr_i == A_CTRL);

    irq_ctrl_unit u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_we_i     (ctrl_we),
        .start_i       (wdata_i[C_START]),
        .mask_i        (wdata_i[C_MASK]),
        .clr_dma_i     (wdata_i[C_CLRD]),
        .clr_proto_i   (wdata_i[C_CLRP]),
        .flush_i       (wdata_i[C_FLUSH]),
        .fatal_any_i   (|fatal_b),
        .irq_any_i     (|irq_b),
        .seq_running_i (seq_running_i),
        .fifo_empty_i  (dma_fifo_empty_i),
        .irq_n_o       (irq_n_o),
        .halt_o        (halt_req_o),
        .mask_o        (mask_q),
        .clr_dma_o     (clr_dma_fifo_o),
        .clr_proto_o   (clr_proto_fifo_o),
        .flush_o       (flush_dma_fifo_o),
        .fifo_empty_o  (fifo_empty_o)
    );

    assign dma_pend_o   = |st[0];
    assign proto_pend_o = |st[1] | |st[2];

    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            3'd0: rd_data_o = {4'b0, fifo_empty_o, halt_req_o, proto_pend_o, dma_pend_o};
            3'd1: rd_data_o = st[0];
            3'd2: rd_data_o = st[1];
            3'd3: rd_data_o = st[2];
            3'd4: rd_data_o = en[0];
            3'd5: rd_data_o = en[1];
            3'd6: rd_data_o = en[2];
            default: rd_data_o[C_MASK] = mask_q;
        endcase
    end
endmodule

// File: rtl/irq_halt_ctrl_chk.sv
module irq_halt_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en_i,
    input logic       wr_en_i,
    input logic [2:0] addr_i,
    input logic [7:0] wdata_i,
    input logic       seq_running_i,
    input logic       dma_pend_o,
    input logic       halt_req_o,
    input logic       irq_n_o,
    input logic       mask_q,
    input logic       clr_dma_fifo_o,
    input logic       flush_dma_fifo_o
);
    assert_dma_fatal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_pend_o && seq_running_i) |=> halt_req_o);

    assert_mask_hides_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> irq_n_o);

    assert_halt_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req_o && !(wr_en_i && addr_i == 3'd7 && wdata_i[0])) |=> halt_req_o);

    assert_dma_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_pend_o && !(rd_en_i && addr_i == 3'd1)) |=> dma_pend_o);

    assert_clr_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_dma_fifo_o |-> $past(wr_en_i && addr_i == 3'd7 && wdata_i[2]));

    assert_flush_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_dma_fifo_o |-> $past(wr_en_i && addr_i == 3'd7 && wdata_i[4]));
endmodule

bind irq_halt_ctrl irq_halt_ctrl_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .rd_en_i          (rd_en_i),
    .wr_en_i          (wr_en_i),
    .addr_i           (addr_i),
    .wdata_i          (wdata_i),
    .seq_running_i    (seq_running_i),
    .dma_pend_o       (dma_pend_o),
    .halt_req_o       (halt_req_o),
    .irq_n_o          (irq_n_o),
    .mask_q           (mask_q),
    .clr_dma_fifo_o   (clr_dma_fifo_o),
    .flush_dma_fifo_o (flush_dma_fifo_o)
);

// File: tb/irq_halt_ctrl_tb.sv
`timescale 1ns/1ps
module irq_halt_ctrl_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] dma_evt = 0, pa_evt = 0, pb_evt = 0;
    logic       mode_t = 0, run = 0, fe_in = 0;
    logic       rd_en = 0, wr_en = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rd_data;
    logic       irq_n, halt, dpend, ppend, fe_out, s_cd, s_cp, s_fl;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] m_st [3];
    logic [7:0] m_en [3];
    logic m_mask, m_halt, m_fe, m_cd, m_cp, m_fl;

    always #2 clk = ~clk;

    irq_halt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dma_evt_i(dma_evt), .proto_a_evt_i(pa_evt),
        .proto_b_evt_i(pb_evt), .mode_target_i(mode_t), .seq_running_i(run),
        .dma_fifo_empty_i(fe_in), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rd_data_o(rd_data), .irq_n_o(irq_n), .halt_req_o(halt),
        .dma_pend_o(dpend), .proto_pend_o(ppend), .fifo_empty_o(fe_out),
        .clr_dma_fifo_o(s_cd), .clr_proto_fifo_o(s_cp), .flush_dma_fifo_o(s_fl)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_fatal();
        logic f;
        f = |m_st[0];
        f = f | |(m_st[1] & (~8'h07 | m_en[1]));
        f = f | |(m_st[2] & (~8'h03 | m_en[2]));
        return f;
    endfunction

    function automatic logic m_irq();
        return |(m_st[0] & m_en[0]) | |(m_st[1] & m_en[1]) | |(m_st[2] & m_en[2]);
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {4'b0, m_fe, m_halt, |m_st[1] | |m_st[2], |m_st[0]};
            3'd1, 3'd2, 3'd3: return m_st[a-1];
            3'd4, 3'd5, 3'd6: return m_en[a-4];
            default: return {6'b0, m_mask, 1'b0};
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        if (a == 0) return "R8 top status";
        if (a < 4)  return "R2 status read";
        return "R10 enable/ctrl read";
    endfunction

    // apply current inputs for one clock; check read data, then outputs
    task automatic tick();
        logic [7:0] ev [3];
        logic fat, we, start;
        #1;
        if (rd_en) chk(rd_tag(addr), rd_data, m_read(addr));
        ev[0] = dma_evt;
        ev[1] = pa_evt;
        if (mode_t) ev[1][2] = 1'b0; else ev[1][1] = 1'b0;
        ev[2] = pb_evt;
        fat   = m_fatal();
        we    = wr_en && addr == 3'd7;
        start = we && wdata[0];
        m_halt = (m_halt & ~(start & ~fat)) | (run & fat);
        if (we) m_mask = wdata[1];
        m_cd = we & wdata[2];
        m_cp = we & wdata[3];
        m_fl = we & wdata[4];
        m_fe = fe_in;
        for (int i = 0; i < 3; i++) begin
            m_st[i] = ((rd_en && addr == 3'(i + 1)) ? 8'h00 : m_st[i]) | ev[i];
            if (wr_en && addr == 3'(i + 4)) m_en[i] = wdata;
        end
        @(negedge clk);
        chk("R6 pin", {7'b0, irq_n}, {7'b0, ~(m_irq() & ~m_mask)});
        chk("R4/R5/R7 halt", {7'b0, halt}, {7'b0, m_halt});
        chk("R8 pending", {6'b0, dpend, ppend}, {6'b0, |m_st[0], |m_st[1] | |m_st[2]});
        chk("R9 strobes/fifo", {4'b0, s_cd, s_cp, s_fl, fe_out}, {4'b0, m_cd, m_cp, m_fl, m_fe});
        dma_evt = 0; pa_evt = 0; pb_evt = 0; rd_en = 0; wr_en = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1; addr = a; wdata = d; tick();
    endtask

    task automatic rd(input logic [2:0] a);
        rd_en = 1; addr = a; tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        for (int i = 0; i < 3; i++) begin m_st[i] = 0; m_en[i] = 0; end
        m_mask = 0; m_halt = 0; m_fe = 0; m_cd = 0; m_cp = 0; m_fl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 pin high", {7'b0, irq_n}, 8'h01);
        chk("R1 halt low", {7'b0, halt}, 8'h00);
        chk("R1 strobes low", {5'b0, s_cd, s_cp, s_fl}, 8'h00);
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a); #1;
            chk("R1 register zero", rd_data, 8'h00);
        end

        // R3: role filtering of selected/reselected strobes
        run = 0; mode_t = 0; pa_evt = 8'h06; tick();
        rd(3'd2);
        chk("R3 initiator drops selected", m_st[1], 8'h00);
        mode_t = 1; pa_evt = 8'h06; tick();
        addr = 3'd2; #1;
        chk("R3 target drops reselected", rd_data, 8'h02);
        rd(3'd2);

        // R2: event in the same cycle as a clearing read survives
        dma_evt = 8'h08; tick();
        rd_en = 1; addr = 3'd1; dma_evt = 8'h08; tick();
        addr = 3'd1; #1;
        chk("R2 same-cycle event kept", rd_data, 8'h08);
        rd(3'd1);

        // R5: nonfatal bit is silent unless enabled; fatal bit halts
        mode_t = 0; run = 1;
        pa_evt = 8'h01; tick(); tick();
        chk("R5 nonfatal no halt", {7'b0, halt}, 8'h00);
        wr(3'd5, 8'h01); tick();
        chk("R5 enabled becomes fatal", {7'b0, halt}, 8'h01);
        chk("R6 enabled pin low", {7'b0, irq_n}, 8'h00);

        // R6: mask hides pin but keeps pending
        wr(3'd7, 8'h02);
        chk("R6 masked pin high", {7'b0, irq_n}, 8'h01);
        wr(3'd7, 8'h00);
        chk("R6 unmask asserts pin", {7'b0, irq_n}, 8'h00);

        // R7: start ignored while fatal bit pending
        wr(3'd7, 8'h01);
        chk("R7 start ignored", {7'b0, halt}, 8'h01);
        rd(3'd2);
        wr(3'd7, 8'h01);
        chk("R7 start accepted", {7'b0, halt}, 8'h00);

        // R4: DMA bit fatal with enables clear
        pb_evt = 8'h80; tick(); rd(3'd3); wr(3'd7, 8'h01);
        dma_evt = 8'h10; tick(); tick();
        chk("R4 dma halts", {7'b0, halt}, 8'h01);
        chk("R6 no enable no pin", {7'b0, irq_n}, 8'h01);

        // R9: strobes and fifo flag
        fe_in = 1; wr(3'd7, 8'h1C);
        chk("R9 all strobes", {5'b0, s_cd, s_cp, s_fl}, 8'h07);
        tick();
        chk("R9 strobes single cycle", {5'b0, s_cd, s_cp, s_fl}, 8'h00);
        chk("R9 fifo empty", {7'b0, fe_out}, 8'h01);

        // random phase
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 7) == 0) dma_evt = 8'(1 << $urandom_range(0, 7));
            if ($urandom_range(0, 5) == 0) pa_evt  = 8'(1 << $urandom_range(0, 7));
            if ($urandom_range(0, 5) == 0) pb_evt  = 8'(1 << $urandom_range(0, 7));
            if ($urandom_range(0, 31) == 0) mode_t = ~mode_t;
            run   = ($urandom_range(0, 7) != 0);
            fe_in = $urandom_range(0, 1) == 1;
            addr  = 3'($urandom_range(0, 7));
            case ($urandom_range(0, 5))
                0, 1: rd_en = 1;
                2: begin
                    wr_en = 1;
                    wdata = 8'($urandom_range(0, 255));
                    if (addr == 3'd7 && $urandom_range(0, 1) == 1) wdata[1] = 1'b0;
                end
                default: ;
            endcase
            tick();
        end
        finish_run();
    end
endmodule